// File: doc/BRIEF.md
# Cache ECC Error Injection Controller

This block lets software corrupt one chosen cache entry on purpose, so that the ECC checking and recovery paths of a cache can be tested. Software programs a physical address and a control word through a simple register bus. Setting the go bit in the control word starts one injection attempt. The controller first checks that ECC checking is switched on and that the chosen array is legal. It then sends a request to the cache, which replies with a response saying whether the address was resident and the corrupting write took place.

Progress shows in a small status state machine that software can read back. It starts at idle, moves to busy, and ends in either done or failed. A failed attempt also carries a reason code. When a register read returns a terminal status (done or failed), the status drops back to idle, so the next attempt can start.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, the control word (offset 0x0) and the address register (offset 0x8) both read 0, and `cache_req_valid` is low.
- R2: In the control word, bit 0 (check enable) and bits 3:2 (target) read back as written. The go bit (bit 1) always reads 0. Bits 63:10 read 0, and so does any offset other than 0x0 or 0x8. A read returns its data with `reg_rvalid` high one cycle after `reg_rd_en`.
- R3: The address register at offset 0x8 keeps the low PA_W bits of the written data. Its upper bits read 0.
- R4: A write to offset 0x0 with go=1, enable=1 and target 0 (metadata) or 2 (data) is accepted while idle. From the next cycle the status (bits 6:4) reads 1 (busy), and `cache_req_valid` is high with `cache_req_addr` and `cache_req_target` copied from the registers. These hold until a response arrives.
- R5: A response with hit=1 while busy sets the status to 2 (done) and drops `cache_req_valid`.
- R6: A response with hit=0 while busy sets the status to 7 (failed), with reason 2 (address not resident) in bits 9:7.
- R7: A go write with enable=0 moves straight to status 7 with reason 0 and never raises `cache_req_valid`.
- R8: A go write with a reserved target (1 or 3) and enable=1 moves straight to status 7 with reason 1 and never raises `cache_req_valid`.
- R9: A read of offset 0x0 that returns status 2 or 7 shows that value, and the status is idle (0) afterwards.
- R10: The reason field keeps its value while the status is 7 and reads 0 while the status is anything else.
- R11: A go write while the status is not idle changes neither the status nor the request outputs. The enable and target fields still take the written value.
- R12: A cache response while the status is not busy has no effect on the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_ofs | input | OFS_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| cache_req_valid | output | 1 | Injection request to the cache |
| cache_req_addr | output | PA_W | Physical address to corrupt |
| cache_req_target | output | 2 | Array selector (0 metadata, 2 data) |
| cache_resp_valid | input | 1 | Cache response strobe |
| cache_resp_hit | input | 1 | 1 = entry resident and corrupted, 0 = miss |

## Verification
Go writes are tried with every combination that picks a different exit from idle:
- enable off, which fails with reason 0;
- both reserved targets, which fail with reason 1;
- the metadata target followed by a hit, which ends in done;
- the data target followed by a miss, which fails with reason 2.

These separate the order of the checks and the mapping from each response to a status. Repeated reads of a terminal status show that the first read returns the value and the second finds idle. Go writes and responses sent while the controller is busy, failed or idle show that requests and responses are accepted only in the right state. Writes of all ones show which register bits can be stored.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_WORK = 3'd1,
    ST_DONE = 3'd2,
    ST_FAIL = 3'd7
  } inj_state_e;

  localparam logic [2:0] RSN_DISABLED = 3'd0;
  localparam logic [2:0] RSN_BAD_TGT  = 3'd1;
  localparam logic [2:0] RSN_MISS     = 3'd2;

  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_GO  = 1;
  localparam int unsigned CTL_TGT = 2;
  localparam int unsigned CTL_ST  = 4;
  localparam int unsigned CTL_RSN = 7;
endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PA_W   = 36,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [DATA_W-1:0] wdata,
  input  inj_state_e        state,
  input  logic [2:0]        reason,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic [PA_W-1:0]   paddr,
  output logic              go,
  output logic              go_en,
  output logic [1:0]        go_tgt,
  output logic              rd_clear
);
  localparam logic [OFS_W-1:0] OFS_CTL  = OFS_W'(0);
  localparam logic [OFS_W-1:0] OFS_ADDR = OFS_W'(8);

  logic            chk_en;
  logic [1:0]      tgt;
  logic [DATA_W-1:0] ctl_word;
  logic            terminal;

  assign go       = wr_en && (ofs == OFS_CTL) && wdata[CTL_GO];
  assign go_en    = wdata[CTL_EN];
  assign go_tgt   = wdata[CTL_TGT +: 2];
  assign terminal = (state == ST_DONE) || (state == ST_FAIL);
  assign rd_clear = rd_en && (ofs == OFS_CTL) && terminal;

  always_comb begin
    ctl_word              = '0;
    ctl_word[CTL_EN]      = chk_en;
    ctl_word[CTL_TGT +: 2] = tgt;
    ctl_word[CTL_ST +: 3] = state;
    ctl_word[CTL_RSN +: 3] = (state == ST_FAIL) ? reason : 3'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_en <= 1'b0;
      tgt    <= 2'd0;
      paddr  <= '0;
    end else if (wr_en) begin
      if (ofs == OFS_CTL) begin
        chk_en <= wdata[CTL_EN];
        tgt    <= wdata[CTL_TGT +: 2];
      end else if (ofs == OFS_ADDR) begin
        paddr  <= wdata[PA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        if (ofs == OFS_CTL)       rdata <= ctl_word;
        else if (ofs == OFS_ADDR) rdata <= DATA_W'(paddr);
        else                      rdata <= '0;
      end
    end
  end

  // R2
  rvalid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
endmodule

// File: rtl/ecc_inj_fsm.sv
module ecc_inj_fsm
  import ecc_inj_pkg::*;
#(
  parameter int PA_W = 36
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go,
  input  logic            go_en,
  input  logic [1:0]      go_tgt,
  input  logic [PA_W-1:0] paddr,
  input  logic            rd_clear,
  input  logic            resp_valid,
  input  logic            resp_hit,
  output inj_state_e      state,
  output logic [2:0]      reason,
  output logic            req_valid,
  output logic [PA_W-1:0] req_addr,
  output logic [1:0]      req_tgt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      reason    <= 3'd0;
      req_valid <= 1'b0;
      req_addr  <= '0;
      req_tgt   <= 2'd0;
    end else begin
      unique case (state)
        ST_IDLE: if (go) begin
          if (!go_en) begin
            state  <= ST_FAIL;
            reason <= RSN_DISABLED;
          end else if (go_tgt[0]) begin
            state  <= ST_FAIL;
            reason <= RSN_BAD_TGT;
          end else begin
            state     <= ST_WORK;
            req_valid <= 1'b1;
            req_addr  <= paddr;
            req_tgt   <= go_tgt;
          end
        end
        ST_WORK: if (resp_valid) begin
          req_valid <= 1'b0;
          if (resp_hit) state <= ST_DONE;
          else begin
            state  <= ST_FAIL;
            reason <= RSN_MISS;
          end
        end
        ST_DONE, ST_FAIL: if (rd_clear) begin
          state  <= ST_IDLE;
          reason <= 3'd0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4
  req_held_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !resp_valid |=> req_valid && $stable(req_addr) && $stable(req_tgt));
  // R5
  hit_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WORK) && resp_valid && resp_hit |=> (state == ST_DONE) && !req_valid);
  // R9
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd_clear |=> (state == ST_IDLE));
  // R10
  reason_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FAIL) && $past(state == ST_FAIL) |-> $stable(reason));
  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WORK) && !resp_valid |=> (state == ST_WORK));
  // R7
  fail_no_req_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) && go && !go_en |=> !req_valid);
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
  import ecc_inj_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PA_W   = 36,
  parameter int OFS_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic              reg_rd_en,
  input  logic [OFS_W-1:0]  reg_ofs,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  output logic              cache_req_valid,
  output logic [PA_W-1:0]   cache_req_addr,
  output logic [1:0]        cache_req_target,
  input  logic              cache_resp_valid,
  input  logic              cache_resp_hit
);
  inj_state_e      state;
  logic [2:0]      reason;
  logic [PA_W-1:0] paddr;
  logic            go, go_en, rd_clear;
  logic [1:0]      go_tgt;

  ecc_inj_regs #(.DATA_W(DATA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en), .ofs(reg_ofs),
    .wdata(reg_wdata), .state(state), .reason(reason), .rdata(reg_rdata),
    .rvalid(reg_rvalid), .paddr(paddr), .go(go), .go_en(go_en),
    .go_tgt(go_tgt), .rd_clear(rd_clear)
  );

  ecc_inj_fsm #(.PA_W(PA_W)) u_fsm (
    .clk(clk), .rst(rst), .go(go), .go_en(go_en), .go_tgt(go_tgt),
    .paddr(paddr), .rd_clear(rd_clear), .resp_valid(cache_resp_valid),
    .resp_hit(cache_resp_hit), .state(state), .reason(reason),
    .req_valid(cache_req_valid), .req_addr(cache_req_addr),
    .req_tgt(cache_req_target)
  );
endmodule

// File: tb/ecc_inject_ctrl_tb.sv
`timescale 1ns/1ps
module ecc_inject_ctrl_tb;
  localparam int DATA_W = 64;
  localparam int PA_W   = 36;
  localparam int OFS_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
  logic [OFS_W-1:0] reg_ofs = '0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic reg_rvalid;
  logic cache_req_valid;
  logic [PA_W-1:0] cache_req_addr;
  logic [1:0] cache_req_target;
  logic cache_resp_valid = 1'b0, cache_resp_hit = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ecc_inject_ctrl #(.DATA_W(DATA_W), .PA_W(PA_W), .OFS_W(OFS_W)) u_dut (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_ofs(reg_ofs), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .cache_req_valid(cache_req_valid),
    .cache_req_addr(cache_req_addr), .cache_req_target(cache_req_target),
    .cache_resp_valid(cache_resp_valid), .cache_resp_hit(cache_resp_hit)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [OFS_W-1:0] ofs, input logic [63:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_ofs = ofs; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [OFS_W-1:0] ofs, output logic [63:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_ofs = ofs;
    @(negedge clk);
    reg_rd_en = 1'b0;
    check("R2 rvalid", 64'(reg_rvalid), 64'd1);
    d = reg_rdata;
  endtask

  task automatic resp(input logic hit);
    @(negedge clk);
    cache_resp_valid = 1'b1; cache_resp_hit = hit;
    @(negedge clk);
    cache_resp_valid = 1'b0; cache_resp_hit = 1'b0;
  endtask

  task automatic t_reset;
    logic [63:0] d;
    rd(4'h0, d); check("R1 ctrl reset", d, 64'h0);
    rd(4'h8, d); check("R1 addr reset", d, 64'h0);
    check("R1 req low", 64'(cache_req_valid), 64'd0);
  endtask

  task automatic t_fields;
    logic [63:0] d;
    wr(4'h0, 64'hFFFF_FFFF_FFFF_FC0D);
    rd(4'h0, d); check("R2 ctrl fields", d, 64'h0D);
    wr(4'h8, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'h8, d); check("R3 addr width", d, 64'h0000_000F_FFFF_FFFF);
    rd(4'h4, d); check("R2 unmapped", d, 64'h0);
    wr(4'h0, 64'h0);
  endtask

  task automatic t_hit;
    logic [63:0] d;
    wr(4'h8, 64'h1234_5678);
    wr(4'h0, 64'h3);
    check("R4 req valid", 64'(cache_req_valid), 64'd1);
    check("R4 req addr", 64'(cache_req_addr), 64'h1234_5678);
    check("R4 req tgt", 64'(cache_req_target), 64'd0);
    rd(4'h0, d); check("R4 busy, R2 go reads 0", d, 64'h11);
    wr(4'h0, 64'h0B);
    check("R11 req kept", 64'(cache_req_valid), 64'd1);
    check("R11 tgt kept", 64'(cache_req_target), 64'd0);
    rd(4'h0, d); check("R11 busy kept", d, 64'h19);
    resp(1'b1);
    check("R5 req dropped", 64'(cache_req_valid), 64'd0);
    rd(4'h0, d); check("R5 done, R9 value", d, 64'h29);
    rd(4'h0, d); check("R9 cleared", d, 64'h09);
  endtask

  task automatic t_miss;
    logic [63:0] d;
    wr(4'h8, 64'hABC);
    wr(4'h0, 64'h0B);
    check("R4 data tgt", 64'(cache_req_target), 64'd2);
    check("R4 addr", 64'(cache_req_addr), 64'hABC);
    resp(1'b0);
    check("R6 req dropped", 64'(cache_req_valid), 64'd0);
    resp(1'b1);
    rd(4'h0, d); check("R6 fail reason2, R12", d, 64'h179);
    rd(4'h0, d); check("R10 reason zero", d, 64'h09);
  endtask

  task automatic t_disabled;
    logic [63:0] d;
    wr(4'h0, 64'h2);
    check("R7 no req", 64'(cache_req_valid), 64'd0);
    wr(4'h0, 64'h3);
    check("R11 no req in fail", 64'(cache_req_valid), 64'd0);
    rd(4'h0, d); check("R7 reason0, R11", d, 64'h71);
    rd(4'h0, d); check("R9 cleared", d, 64'h01);
  endtask

  task automatic t_badtgt;
    logic [63:0] d;
    wr(4'h0, 64'h7);
    check("R8 no req tgt1", 64'(cache_req_valid), 64'd0);
    rd(4'h0, d); check("R8 reason1 tgt1", d, 64'hF5);
    wr(4'h0, 64'hF);
    check("R8 no req tgt3", 64'(cache_req_valid), 64'd0);
    rd(4'h0, d); check("R8 reason1 tgt3", d, 64'hFD);
  endtask

  task automatic t_stray;
    logic [63:0] d;
    resp(1'b1);
    rd(4'h0, d); check("R12 idle kept", d, 64'h0D);
    check("R12 no req", 64'(cache_req_valid), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fields();
    t_hit();
    t_miss();
    t_disabled();
    t_badtgt();
    t_stray();
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule